// File: doc/BRIEF.md
# CAN Transmit Slot Scheduler

This block picks which transmit slot the CAN protocol engine sends next. It also keeps the per-slot status that host software reads. There are `N_SLOT` slots in all. The lowest `N_DED` of them are dedicated slots: the host fills each one and requests it by its own index. The remaining slots form a shared group.

A configuration bit sets how the shared group behaves:

- **Ordered ring (bit = 0).** Entries leave in the order they were loaded. A put pointer, a get pointer and a fill count track the ring.
- **Priority pool (bit = 1).** The pending entry with the numerically smallest identifier leaves first. New entries go into the lowest-numbered free slot.

In both settings the dedicated slots compete with the eligible group slots on identifier.

The host side is a one-cycle add strobe that carries an identifier, plus a one-cycle cancel strobe. The engine side is a level request that holds the chosen slot index and its identifier until the engine returns a done pulse with a success bit. On success the slot's pending bit clears and its transmitted bit sets. On failure the slot stays pending and the choice is made again. Status outputs are:

- the pending and transmitted bitmaps;
- the put and get pointers;
- the free-slot count;
- a group-full flag;
- a ring-empty flag, which is usable as an interrupt;
- a sticky ring-overflow flag.

The mode bit is meant to change only while the block is in reset.

Top module: `can_txbuf_mgr`

## Requirements
- R1: An add with `add_grp`=0 and `add_slot` below `N_DED` sets `pend_o[add_slot]`, clears `occ_o[add_slot]` and stores `add_id` for that slot. An add with `add_grp`=0 and `add_slot` of `N_DED` or above changes nothing.
- R2: An add aimed at a slot whose pending bit is already 1 is ignored. The stored identifier is kept.
- R3: With `cfg_queue_mode`=0, group slot `N_DED+k` is the only group slot eligible, where k is `get_idx_o`. Group entries therefore leave in load order, whatever their identifiers. Each successful send of that slot advances `get_idx_o` by one, wrapping from `N_SLOT-N_DED-1` to 0.
- R4: With `cfg_queue_mode`=0, each accepted group add fills slot `N_DED+put_idx_o` and advances `put_idx_o` cyclically. `free_lvl_o` equals `N_SLOT-N_DED` minus the number of loaded, unsent entries.
- R5: With `cfg_queue_mode`=0 and the ring full, `grp_full_o`=1 and `free_lvl_o`=0. A further group add changes no slot or pointer and sets `ovf_o`. `ovf_o` stays 1 until reset.
- R6: Among the eligible pending slots (all dedicated slots, plus the group slots that the mode allows), the one with the smallest identifier is sent first. On equal identifiers the lower slot index wins.
- R7: With `cfg_queue_mode`=1:
  - `put_idx_o` is the group-relative index of the lowest-numbered non-pending group slot, or 0 when every group slot is pending.
  - `grp_full_o`=1 exactly when every group slot is pending.
  - A group add when full is ignored and leaves `ovf_o` unchanged.
- R8: A done pulse with `eng_ok`=1 clears the pending bit of the requested slot and sets its `occ_o` bit at the same edge. With `eng_ok`=0 the slot stays pending, and a new choice is made.
- R9: `fifo_empty_o` is 1 when `cfg_queue_mode`=0 and the ring holds no entry. It is always 0 when `cfg_queue_mode`=1.
- R10: A cancel clears the pending bit of a pending slot without setting its `occ_o` bit. A cancel is ignored in either of these cases:
  - the slot is the one being requested from the engine;
  - `cfg_queue_mode`=0 and the slot is a group slot.
- R11: When the engine is idle, `eng_req` rises one clock edge after a pending bit becomes visible. `eng_slot` and `eng_id` stay stable until the done pulse.
- R12: After reset, all of the following hold:
  - `pend_o` and `occ_o` are zero;
  - the pointers are 0;
  - `free_lvl_o` is `N_SLOT-N_DED`;
  - `grp_full_o`, `ovf_o` and `eng_req` are 0;
  - `fifo_empty_o` is 1 in ring mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_queue_mode | input | 1 | Group mode: 0 ordered ring, 1 priority pool |
| add_valid | input | 1 | One-cycle add strobe |
| add_grp | input | 1 | 1: add to the group; 0: add to dedicated slot `add_slot` |
| add_slot | input | SLOT_W | Dedicated slot index for an add |
| add_id | input | ID_W | Identifier of the message being added |
| cancel_valid | input | 1 | One-cycle cancel strobe |
| cancel_slot | input | SLOT_W | Slot index to cancel |
| eng_req | output | 1 | Send request to the protocol engine |
| eng_slot | output | SLOT_W | Slot being requested |
| eng_id | output | ID_W | Identifier of the requested slot |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| eng_ok | input | 1 | Completion succeeded (valid with `eng_done`) |
| pend_o | output | N_SLOT | Pending bitmap, bit i for slot i |
| occ_o | output | N_SLOT | Transmitted bitmap, bit i for slot i |
| put_idx_o | output | GRP_W | Group-relative put pointer |
| get_idx_o | output | GRP_W | Group-relative get pointer (0 in priority mode) |
| free_lvl_o | output | LVL_W | Number of free group slots |
| grp_full_o | output | 1 | No group slot free |
| fifo_empty_o | output | 1 | Ring mode and ring empty |
| ovf_o | output | 1 | Sticky ring overflow |

## Verification
The bitmaps, the ring pointers and the overflow flag are registered. An add, a cancel or a done pulse therefore shows on `pend_o`, `occ_o`, the pointers and `ovf_o` at the first rising edge after the strobe. `free_lvl_o`, `grp_full_o`, `fifo_empty_o` and the priority-mode put pointer are decoded from that state, so they change at the same edge. `eng_req` with its slot and identifier needs one more edge, because the choice is latched from the already-updated pending bits. The bench drives every strobe just after a falling edge and samples at the next falling edge, one edge later. It waits one further edge before looking for a request, and its serving task polls `eng_req` at falling edges instead of assuming a fixed latency.

// File: rtl/tbm_pkg.sv
package tbm_pkg;

  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_BUSY = 1'b1
  } eng_state_e;

  // next position on a ring of len entries
  function automatic int unsigned ring_step(int unsigned idx, int unsigned len);
    return (idx + 1 >= len) ? 0 : idx + 1;
  endfunction

  // free entries left when used of len are occupied
  function automatic int unsigned free_count(int unsigned len, int unsigned used);
    return (used >= len) ? 0 : len - used;
  endfunction

endpackage

// File: rtl/tbm_pick.sv
module tbm_pick #(
  parameter int N_SLOT = 8,
  parameter int ID_W   = 11,
  localparam int SLOT_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
  input  logic [N_SLOT-1:0]           cand,
  input  logic [N_SLOT-1:0][ID_W-1:0] ids,
  output logic                        any,
  output logic [SLOT_W-1:0]           slot,
  output logic [ID_W-1:0]             id
);

  // lowest identifier wins; strict compare keeps the lower index on a tie
  always_comb begin
    any  = 1'b0;
    slot = '0;
    id   = '0;
    for (int i = 0; i < N_SLOT; i++) begin
      if (cand[i] && (!any || (ids[i] < id))) begin
        any  = 1'b1;
        slot = SLOT_W'(i);
        id   = ids[i];
      end
    end
  end

endmodule

// File: rtl/tbm_slot_bank.sv
module tbm_slot_bank #(
  parameter int N_SLOT = 8,
  parameter int ID_W   = 11,
  localparam int SLOT_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        set_en,
  input  logic [SLOT_W-1:0]           set_slot,
  input  logic [ID_W-1:0]             set_id,
  input  logic                        sent_en,
  input  logic [SLOT_W-1:0]           sent_slot,
  input  logic                        drop_en,
  input  logic [SLOT_W-1:0]           drop_slot,
  output logic [N_SLOT-1:0]           pend,
  output logic [N_SLOT-1:0]           occ,
  output logic [N_SLOT-1:0][ID_W-1:0] ids
);

  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    logic hit_set, hit_sent, hit_drop;
    assign hit_set  = set_en  && (set_slot  == SLOT_W'(g));
    assign hit_sent = sent_en && (sent_slot == SLOT_W'(g));
    assign hit_drop = drop_en && (drop_slot == SLOT_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[g] <= 1'b0;
        occ[g]  <= 1'b0;
        ids[g]  <= '0;
      end else if (hit_set) begin
        pend[g] <= 1'b1;
        occ[g]  <= 1'b0;
        ids[g]  <= set_id;
      end else if (hit_sent) begin
        pend[g] <= 1'b0;
        occ[g]  <= 1'b1;
      end else if (hit_drop) begin
        pend[g] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tbm_grp_ctl.sv
module tbm_grp_ctl
  import tbm_pkg::*;
#(
  parameter int N_GRP = 5,
  localparam int GRP_W = (N_GRP > 1) ? $clog2(N_GRP) : 1,
  localparam int LVL_W = $clog2(N_GRP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             queue_mode,
  input  logic [N_GRP-1:0] grp_pend,
  input  logic             push_req,
  input  logic             pop,
  output logic             push_ok,
  output logic [GRP_W-1:0] put_idx,
  output logic [GRP_W-1:0] get_idx,
  output logic [LVL_W-1:0] free_lvl,
  output logic             full,
  output logic             empty,
  output logic             ovf
);

  logic [GRP_W-1:0] fput_q, fget_q;
  logic [LVL_W-1:0] fcnt_q;
  logic             ovf_q;

  // priority-pool view, decoded from the pending bits
  logic [GRP_W-1:0] qput;
  logic [LVL_W-1:0] qused;
  logic             qfull;

  always_comb begin
    qput = '0;
    for (int i = N_GRP - 1; i >= 0; i--) begin
      if (!grp_pend[i]) qput = GRP_W'(i);
    end
  end

  assign qused = LVL_W'($countones(grp_pend));
  assign qfull = &grp_pend;

  logic ring_full;
  assign ring_full = (fcnt_q == LVL_W'(N_GRP));

  assign full     = queue_mode ? qfull : ring_full;
  assign push_ok  = push_req && !full;
  assign put_idx  = queue_mode ? qput : fput_q;
  assign get_idx  = queue_mode ? '0 : fget_q;
  assign free_lvl = LVL_W'(free_count(N_GRP, 32'(queue_mode ? qused : fcnt_q)));
  assign empty    = !queue_mode && (fcnt_q == '0);
  assign ovf      = ovf_q;

  logic ring_push, ring_pop;
  assign ring_push = push_ok && !queue_mode;
  assign ring_pop  = pop && !queue_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fput_q <= '0;
      fget_q <= '0;
      fcnt_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (ring_push) fput_q <= GRP_W'(ring_step(32'(fput_q), N_GRP));
      if (ring_pop)  fget_q <= GRP_W'(ring_step(32'(fget_q), N_GRP));
      case ({ring_push, ring_pop})
        2'b10:   fcnt_q <= fcnt_q + 1'b1;
        2'b01:   fcnt_q <= fcnt_q - 1'b1;
        default: fcnt_q <= fcnt_q;
      endcase
      if (push_req && !queue_mode && ring_full) ovf_q <= 1'b1;
    end
  end

endmodule

// File: rtl/can_txbuf_mgr.sv
module can_txbuf_mgr
  import tbm_pkg::*;
#(
  parameter int N_SLOT = 8,
  parameter int N_DED  = 3,
  parameter int ID_W   = 11,
  localparam int SLOT_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1,
  localparam int N_GRP  = N_SLOT - N_DED,
  localparam int GRP_W  = (N_GRP > 1) ? $clog2(N_GRP) : 1,
  localparam int LVL_W  = $clog2(N_GRP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_queue_mode,
  input  logic              add_valid,
  input  logic              add_grp,
  input  logic [SLOT_W-1:0] add_slot,
  input  logic [ID_W-1:0]   add_id,
  input  logic              cancel_valid,
  input  logic [SLOT_W-1:0] cancel_slot,
  output logic              eng_req,
  output logic [SLOT_W-1:0] eng_slot,
  output logic [ID_W-1:0]   eng_id,
  input  logic              eng_done,
  input  logic              eng_ok,
  output logic [N_SLOT-1:0] pend_o,
  output logic [N_SLOT-1:0] occ_o,
  output logic [GRP_W-1:0]  put_idx_o,
  output logic [GRP_W-1:0]  get_idx_o,
  output logic [LVL_W-1:0]  free_lvl_o,
  output logic              grp_full_o,
  output logic              fifo_empty_o,
  output logic              ovf_o
);

  // ---------------- slot state ----------------
  logic [N_SLOT-1:0]           pend, occ;
  logic [N_SLOT-1:0][ID_W-1:0] ids;

  // ---------------- named events ----------------
  logic              launch;
  logic              done_ok;
  logic              pop;
  logic              push_req, push_ok;
  logic              ded_ok;
  logic              cancel_ok;
  logic              set_en;
  logic [SLOT_W-1:0] set_slot;

  // ---------------- engine handshake state ----------------
  eng_state_e        st_q;
  logic [SLOT_W-1:0] cur_slot_q;
  logic [ID_W-1:0]   cur_id_q;

  // ---------------- group control ----------------
  logic [GRP_W-1:0] put_idx, get_idx;
  logic             grp_full;

  tbm_grp_ctl #(.N_GRP(N_GRP)) u_grp (
    .clk        (clk),
    .rst_n      (rst_n),
    .queue_mode (cfg_queue_mode),
    .grp_pend   (pend[N_SLOT-1:N_DED]),
    .push_req   (push_req),
    .pop        (pop),
    .push_ok    (push_ok),
    .put_idx    (put_idx),
    .get_idx    (get_idx),
    .free_lvl   (free_lvl_o),
    .full       (grp_full),
    .empty      (fifo_empty_o),
    .ovf        (ovf_o)
  );

  // ---------------- eligibility ----------------
  logic [N_SLOT-1:0] cand;
  for (genvar g = 0; g < N_SLOT; g++) begin : g_cand
    if (g < N_DED) begin : g_ded
      assign cand[g] = pend[g];
    end else begin : g_grp
      assign cand[g] = pend[g] &&
                       (cfg_queue_mode || (get_idx == GRP_W'(g - N_DED)));
    end
  end

  logic              pick_any;
  logic [SLOT_W-1:0] pick_slot;
  logic [ID_W-1:0]   pick_id;

  tbm_pick #(.N_SLOT(N_SLOT), .ID_W(ID_W)) u_pick (
    .cand (cand),
    .ids  (ids),
    .any  (pick_any),
    .slot (pick_slot),
    .id   (pick_id)
  );

  // ---------------- host decode ----------------
  function automatic logic is_ded(logic [SLOT_W-1:0] s);
    return {1'b0, s} < (SLOT_W+1)'(N_DED);
  endfunction

  function automatic logic in_range(logic [SLOT_W-1:0] s);
    return {1'b0, s} < (SLOT_W+1)'(N_SLOT);
  endfunction

  logic busy;
  assign busy = (st_q == ENG_BUSY);

  assign launch   = !busy && pick_any;
  assign done_ok  = busy && eng_done && eng_ok;
  assign pop      = done_ok && !cfg_queue_mode && !is_ded(cur_slot_q) &&
                    (cur_slot_q == SLOT_W'(N_DED) + SLOT_W'(get_idx));

  assign ded_ok   = add_valid && !add_grp && is_ded(add_slot) && !pend[add_slot];
  assign push_req = add_valid && add_grp;
  assign set_en   = ded_ok || push_ok;
  assign set_slot = ded_ok ? add_slot : (SLOT_W'(N_DED) + SLOT_W'(put_idx));

  logic cancel_locked;
  assign cancel_locked = (busy && (cur_slot_q == cancel_slot)) ||
                         (launch && (pick_slot == cancel_slot)) ||
                         (!cfg_queue_mode && !is_ded(cancel_slot));
  assign cancel_ok = cancel_valid && in_range(cancel_slot) &&
                     pend[cancel_slot] && !cancel_locked;

  tbm_slot_bank #(.N_SLOT(N_SLOT), .ID_W(ID_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en    (set_en),
    .set_slot  (set_slot),
    .set_id    (add_id),
    .sent_en   (done_ok),
    .sent_slot (cur_slot_q),
    .drop_en   (cancel_ok),
    .drop_slot (cancel_slot),
    .pend      (pend),
    .occ       (occ),
    .ids       (ids)
  );

  // ---------------- engine handshake ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ENG_IDLE;
      cur_slot_q <= '0;
      cur_id_q   <= '0;
    end else if (!busy) begin
      if (pick_any) begin
        st_q       <= ENG_BUSY;
        cur_slot_q <= pick_slot;
        cur_id_q   <= pick_id;
      end
    end else if (eng_done) begin
      st_q <= ENG_IDLE;
    end
  end

  // ---------------- outputs ----------------
  assign eng_req    = busy;
  assign eng_slot   = cur_slot_q;
  assign eng_id     = cur_id_q;
  assign pend_o     = pend;
  assign occ_o      = occ;
  assign put_idx_o  = (cfg_queue_mode && grp_full) ? '0 : put_idx;
  assign get_idx_o  = get_idx;
  assign grp_full_o = grp_full;

endmodule

// File: rtl/tbm_checker.sv
module tbm_checker #(
  parameter int N_SLOT = 8,
  parameter int N_DED  = 3,
  parameter int ID_W   = 11,
  localparam int SLOT_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1,
  localparam int N_GRP  = N_SLOT - N_DED,
  localparam int GRP_W  = (N_GRP > 1) ? $clog2(N_GRP) : 1,
  localparam int LVL_W  = $clog2(N_GRP + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_queue_mode,
  input logic              eng_req,
  input logic [SLOT_W-1:0] eng_slot,
  input logic [ID_W-1:0]   eng_id,
  input logic              eng_done,
  input logic              eng_ok,
  input logic [N_SLOT-1:0] pend_o,
  input logic [N_SLOT-1:0] occ_o,
  input logic [GRP_W-1:0]  get_idx_o,
  input logic [LVL_W-1:0]  free_lvl_o,
  input logic              grp_full_o,
  input logic              fifo_empty_o,
  input logic              ovf_o,
  input logic              launch,
  input logic [SLOT_W-1:0] pick_slot,
  input logic              cancel_ok,
  input logic [SLOT_W-1:0] cancel_slot
);

  // R11: a held request keeps its slot and identifier
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_done) |=> (eng_req && $stable(eng_slot) && $stable(eng_id)));

  // R11: only a pending slot is ever requested
  a_r11_req_pending: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |-> pend_o[eng_slot]);

  // R8: success retires the slot and marks it transmitted
  a_r8_success: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && eng_done && eng_ok) |=> (occ_o[$past(eng_slot)] && !pend_o[$past(eng_slot)]));

  // R8: failure keeps the slot pending
  a_r8_failure: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && eng_done && !eng_ok) |=> pend_o[$past(eng_slot)]);

  // R3: in ring mode a launched group slot is the one at the get pointer
  a_r3_ring_head: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !cfg_queue_mode && ({1'b0, pick_slot} >= (SLOT_W+1)'(N_DED))) |->
      (pick_slot == SLOT_W'(N_DED) + SLOT_W'(get_idx_o)));

  // R4: free count never exceeds the group size
  a_r4_free_range: assert property (@(posedge clk) disable iff (!rst_n)
    free_lvl_o <= LVL_W'(N_GRP));

  // R5: ring full flag agrees with a zero free count
  a_r5_full_level: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_queue_mode |-> (grp_full_o == (free_lvl_o == '0)));

  // R5: overflow is sticky
  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);

  // R7: priority mode never raises overflow
  a_r7_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_queue_mode && !ovf_o) |=> !ovf_o);

  // R9: ring-empty flag stays low in priority mode
  a_r9_empty_mode: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_queue_mode |-> !fifo_empty_o);

  // R10: an accepted cancel clears pending and leaves transmitted low
  a_r10_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_ok |=> (!pend_o[$past(cancel_slot)] && !occ_o[$past(cancel_slot)]));

endmodule

bind can_txbuf_mgr tbm_checker #(
  .N_SLOT (N_SLOT),
  .N_DED  (N_DED),
  .ID_W   (ID_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_queue_mode (cfg_queue_mode),
  .eng_req        (eng_req),
  .eng_slot       (eng_slot),
  .eng_id         (eng_id),
  .eng_done       (eng_done),
  .eng_ok         (eng_ok),
  .pend_o         (pend_o),
  .occ_o          (occ_o),
  .get_idx_o      (get_idx_o),
  .free_lvl_o     (free_lvl_o),
  .grp_full_o     (grp_full_o),
  .fifo_empty_o   (fifo_empty_o),
  .ovf_o          (ovf_o),
  .launch         (launch),
  .pick_slot      (pick_slot),
  .cancel_ok      (cancel_ok),
  .cancel_slot    (cancel_slot)
);

// File: tb/sim_can_txbuf_mgr.sv
module sim_can_txbuf_mgr;

  localparam int CLK_PERIOD = 10;
  localparam int NS   = 8;
  localparam int ND   = 3;
  localparam int NG   = NS - ND;
  localparam int IDW  = 11;
  localparam int SW   = 3;
  localparam int GW   = 3;
  localparam int LW   = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cfg_queue_mode = 1'b0;
  logic           add_valid = 1'b0;
  logic           add_grp = 1'b0;
  logic [SW-1:0]  add_slot = '0;
  logic [IDW-1:0] add_id = '0;
  logic           cancel_valid = 1'b0;
  logic [SW-1:0]  cancel_slot = '0;
  logic           eng_req;
  logic [SW-1:0]  eng_slot;
  logic [IDW-1:0] eng_id;
  logic           eng_done = 1'b0;
  logic           eng_ok = 1'b0;
  logic [NS-1:0]  pend_o, occ_o;
  logic [GW-1:0]  put_idx_o, get_idx_o;
  logic [LW-1:0]  free_lvl_o;
  logic           grp_full_o, fifo_empty_o, ovf_o;

  can_txbuf_mgr #(.N_SLOT(NS), .N_DED(ND), .ID_W(IDW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_queue_mode(cfg_queue_mode),
    .add_valid(add_valid), .add_grp(add_grp), .add_slot(add_slot), .add_id(add_id),
    .cancel_valid(cancel_valid), .cancel_slot(cancel_slot),
    .eng_req(eng_req), .eng_slot(eng_slot), .eng_id(eng_id),
    .eng_done(eng_done), .eng_ok(eng_ok),
    .pend_o(pend_o), .occ_o(occ_o), .put_idx_o(put_idx_o), .get_idx_o(get_idx_o),
    .free_lvl_o(free_lvl_o), .grp_full_o(grp_full_o), .fifo_empty_o(fifo_empty_o),
    .ovf_o(ovf_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  // bench model of the slots for the priority sweeps
  bit m_pend [NS];
  int m_id   [NS];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset(input bit mode);
    rst_n = 1'b0;
    cfg_queue_mode = mode;
    add_valid = 1'b0; cancel_valid = 1'b0; eng_done = 1'b0; eng_ok = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic add_ded(input int slot, input int id);
    add_valid = 1'b1; add_grp = 1'b0; add_slot = SW'(slot); add_id = IDW'(id);
    tick();
    add_valid = 1'b0;
  endtask

  task automatic add_group(input int id);
    add_valid = 1'b1; add_grp = 1'b1; add_slot = '0; add_id = IDW'(id);
    tick();
    add_valid = 1'b0; add_grp = 1'b0;
  endtask

  task automatic do_cancel(input int slot);
    cancel_valid = 1'b1; cancel_slot = SW'(slot);
    tick();
    cancel_valid = 1'b0;
  endtask

  task automatic serve(input bit ok, output int s, output int id);
    for (int w = 0; w < 20 && !eng_req; w++) tick();
    check(eng_req === 1'b1, "R11 request expected", int'(eng_req), 1);
    s  = int'(eng_slot);
    id = int'(eng_id);
    eng_done = 1'b1; eng_ok = ok;
    tick();
    eng_done = 1'b0; eng_ok = 1'b0;
  endtask

  function automatic int qid(input int p, input int i);
    return ((i * (2 * p + 1) + p) % (p + 3)) * 33 + 1;
  endfunction

  function automatic int model_best();
    int b = -1;
    for (int i = 0; i < NS; i++)
      if (m_pend[i] && (b < 0 || m_id[i] < m_id[b])) b = i;
    return b;
  endfunction

  function automatic int model_put();
    for (int i = 0; i < NG; i++) if (!m_pend[ND + i]) return i;
    return 0;
  endfunction

  function automatic bit model_full();
    for (int i = 0; i < NG; i++) if (!m_pend[ND + i]) return 1'b0;
    return 1'b1;
  endfunction

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int s, id, put_cum, p0, pm;

    // ---------------- reset state (R12, R9) ----------------
    do_reset(1'b0);
    chk_eq("R12 pend after reset", int'(pend_o), 0);
    chk_eq("R12 occ after reset", int'(occ_o), 0);
    chk_eq("R12 put after reset", int'(put_idx_o), 0);
    chk_eq("R12 get after reset", int'(get_idx_o), 0);
    chk_eq("R12 free after reset", int'(free_lvl_o), NG);
    chk_eq("R12 full after reset", int'(grp_full_o), 0);
    chk_eq("R12 ovf after reset", int'(ovf_o), 0);
    chk_eq("R12 req after reset", int'(eng_req), 0);
    chk_eq("R9 ring empty after reset", int'(fifo_empty_o), 1);

    // ---------------- ring mode sweep (R3, R4, R9) ----------------
    put_cum = 0;
    for (int k = 1; k <= NG; k++) begin
      for (int j = 0; j < k; j++) begin
        add_group(12'h700 - j * 16 - k);
        chk_eq("R4 put advance", int'(put_idx_o), (put_cum + j + 1) % NG);
        chk_eq("R4 free level", int'(free_lvl_o), NG - j - 1);
        chk_eq("R9 not empty", int'(fifo_empty_o), 0);
        chk_eq("R5 full flag", int'(grp_full_o), (j + 1 == NG) ? 1 : 0);
      end
      for (int j = 0; j < k; j++) begin
        serve(1'b1, s, id);
        chk_eq("R3 load order slot", s, ND + (put_cum + j) % NG);
        chk_eq("R3 load order id", id, 12'h700 - j * 16 - k);
        chk_eq("R8 occurred set", int'(occ_o[s]), 1);
      end
      put_cum += k;
      chk_eq("R3 get wraps to put", int'(get_idx_o), put_cum % NG);
      chk_eq("R9 empty after drain", int'(fifo_empty_o), 1);
      chk_eq("R4 free after drain", int'(free_lvl_o), NG);
    end

    // ---------------- ring overflow (R5, R10) ----------------
    p0 = put_cum % NG;
    for (int j = 0; j < NG; j++) add_group(12'h400 + j);
    pm = int'(pend_o);
    add_group(12'h001);
    chk_eq("R5 overflow set", int'(ovf_o), 1);
    chk_eq("R5 put unchanged", int'(put_idx_o), p0);
    chk_eq("R5 free zero", int'(free_lvl_o), 0);
    chk_eq("R5 pend unchanged", int'(pend_o), pm);
    do_cancel(ND + (p0 + 1) % NG);
    chk_eq("R10 ring cancel ignored", int'(pend_o[ND + (p0 + 1) % NG]), 1);
    for (int j = 0; j < NG; j++) begin
      serve(1'b1, s, id);
      chk_eq("R3 order after overflow", id, 12'h400 + j);
    end
    chk_eq("R5 overflow sticky", int'(ovf_o), 1);

    // ---------------- priority sweeps (R6, R7, R8, R9) ----------------
    for (int p = 0; p < 6; p++) begin
      do_reset(1'b1);
      chk_eq("R9 no empty flag in pool mode", int'(fifo_empty_o), 0);
      for (int i = 0; i < NS; i++) begin m_pend[i] = 1'b0; m_id[i] = 0; end
      for (int i = 0; i < ND; i++) begin
        add_ded(i, qid(p, i));
        m_pend[i] = 1'b1; m_id[i] = qid(p, i);
      end
      for (int j = 0; j < NG; j++) begin
        add_group(qid(p, ND + j));
        m_pend[ND + j] = 1'b1; m_id[ND + j] = qid(p, ND + j);
        chk_eq("R7 put lowest free", int'(put_idx_o), model_put());
        chk_eq("R7 full flag", int'(grp_full_o), int'(model_full()));
      end
      add_group(12'h002);
      chk_eq("R7 add when full ignored", int'(pend_o), (1 << NS) - 1);
      chk_eq("R7 no overflow in pool mode", int'(ovf_o), 0);
      serve(1'b0, s, id);
      chk_eq("R8 failed slot", s, 0);
      chk_eq("R8 failed stays pending", int'(pend_o[0]), 1);
      chk_eq("R8 failed not occurred", int'(occ_o[0]), 0);
      for (int n = 0; n < NS; n++) begin
        int b;
        b = model_best();
        serve(1'b1, s, id);
        chk_eq("R6 priority slot", s, b);
        chk_eq("R6 priority id", id, m_id[b]);
        m_pend[b] = 1'b0;
        chk_eq("R8 pending cleared", int'(pend_o[b]), 0);
        chk_eq("R8 occurred set", int'(occ_o[b]), 1);
        chk_eq("R7 put after send", int'(put_idx_o), model_put());
        chk_eq("R7 full after send", int'(grp_full_o), int'(model_full()));
      end
    end

    // ---------------- dedicated, duplicate, cancel (R1, R2, R10, R11) ----------------
    do_reset(1'b1);
    add_ded(0, 12'h010);
    chk_eq("R1 pending set", int'(pend_o[0]), 1);
    chk_eq("R11 no request yet", int'(eng_req), 0);
    tick();
    chk_eq("R11 request one edge later", int'(eng_req), 1);
    chk_eq("R11 request slot", int'(eng_slot), 0);
    chk_eq("R11 request id", int'(eng_id), 12'h010);
    add_ded(1, 12'h020);
    add_ded(2, 12'h030);
    add_ded(1, 12'h005);
    do_cancel(2);
    chk_eq("R10 cancel clears pending", int'(pend_o[2]), 0);
    chk_eq("R10 cancel no occurred", int'(occ_o[2]), 0);
    do_cancel(0);
    chk_eq("R10 in-flight cancel ignored", int'(pend_o[0]), 1);
    add_ded(5, 12'h001);
    chk_eq("R1 non-dedicated index ignored", int'(pend_o), 3);
    chk_eq("R11 slot held", int'(eng_slot), 0);
    serve(1'b1, s, id);
    chk_eq("R1 first sent", s, 0);
    serve(1'b1, s, id);
    chk_eq("R2 duplicate add slot", s, 1);
    chk_eq("R2 duplicate add keeps id", id, 12'h020);
    chk_eq("R8 occurred bitmap", int'(occ_o), 3);
    add_ded(0, 12'h040);
    chk_eq("R1 re-add clears occurred", int'(occ_o[0]), 0);
    chk_eq("R1 re-add pending", int'(pend_o[0]), 1);
    serve(1'b1, s, id);
    chk_eq("R1 re-add id", id, 12'h040);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule